// File: doc/BRIEF.md
# Sync Clamp and Vertical Blanking Generator

This block produces a two-level sandcastle code for a downstream video interface. The upper level is a short clamp pulse that follows each line sync pulse, and the lower level is a vertical blanking interval. The output is a 2-bit level code plus a separate unlock-blank line. The clamp pulse is timed from either the leading or the trailing edge of the normalized horizontal sync. A fixed start delay and a fixed width are applied, each a clock-count parameter. Vertical blanking opens on the rising edge of the vertical sync. It closes on the vertical scan-start strobe, or when a selectable width runs out, whichever comes first.

Several fault conditions force blanking continuously: soft start, loss of phase lock while the frequency search runs, missing flyback pulses, X-ray protection and low supply. A mask input removes only the unlock-caused part. All inputs are synchronous to `clk_i`, and the analog levels are produced outside the block.

Top module: `sandcastle_gen`

## Requirements
- R1: After reset, with all inputs low, `level_o` is 2'b00 (none) and `unlock_blank_o` is 0.
- R2: With `clamp_lead_i`=1, a rising edge of `hsync_i` seen at clock edge k drives `level_o`=2'b10 (clamp) after edges k+CLAMP_DLY_LEAD through k+CLAMP_DLY_LEAD+CLAMP_W-1, exactly CLAMP_W cycles.
- R3: With `clamp_lead_i`=0, a falling edge of `hsync_i` triggers the same pulse with start delay CLAMP_DLY_TRAIL instead.
- R4: Sync edges that arrive while a clamp sequence (delay plus pulse) is still running are ignored. They neither restart nor extend it.
- R5: A rising edge of `vsync_i` starts vertical blanking (code 2'b01 when no clamp) for VBLANK_SHORT cycles when `vblank_long_i`=0, or VBLANK_LONG cycles when it is 1. A new rising edge restarts the interval.
- R6: A `vscan_start_i` strobe during vertical blanking ends it at the next clock edge.
- R7: Any of `softstart_i`, `xray_i` or `low_supply_i` forces blanking on both outputs for as long as it is high.
- R8: `pll_unlock_i` and `search_i` both high force blanking unless `unlock_mask_i` is 1. The mask has no effect on vertical blanking or on the other faults.
- R9: Flyback is declared missing, forcing blanking, once MISS_LINES=2 leading sync edges pass with no rising edge of `flyback_i`. A flyback rising edge clears the condition at the next clock edge and takes priority over a sync edge in the same cycle.
- R10: When clamp and any blanking are active in the same cycle, `level_o` shows clamp (2'b10).
- R11: `unlock_blank_o` is 1 exactly when vertical blanking or any unmasked forced blanking is active, independent of the clamp pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Normalized horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| vscan_start_i | input | 1 | Vertical scan-start strobe |
| flyback_i | input | 1 | Line flyback pulse |
| softstart_i | input | 1 | Soft start active |
| pll_unlock_i | input | 1 | Phase loop not locked |
| search_i | input | 1 | Frequency loop in search mode |
| xray_i | input | 1 | X-ray protection tripped |
| low_supply_i | input | 1 | Supply below threshold |
| clamp_lead_i | input | 1 | 1: clamp from leading edge, 0: from trailing edge |
| vblank_long_i | input | 1 | 1: long vertical blank, 0: short |
| unlock_mask_i | input | 1 | Suppress unlock-caused continuous blanking |
| level_o | output | 2 | Sandcastle code: 00 none, 01 blank, 10 clamp |
| unlock_blank_o | output | 1 | Vertical blank or forced blank, no clamp |

## Verification
The clamp pulse and blanking are the two functions that fall in the same cycle. Line syncs run continuously while vertical sync pulses and fault inputs are applied, so clamp pulses land inside the blanking intervals. In those cycles `level_o` must read clamp while `unlock_blank_o` stays high. A behavioural model in the bench predicts both outputs on every cycle, and directed counts check the clamp width and the blank length.

// File: rtl/sandcastle_pkg.sv
package sandcastle_pkg;
  typedef enum logic [1:0] {
    LVL_NONE  = 2'b00,
    LVL_BLANK = 2'b01,
    LVL_CLAMP = 2'b10
  } sc_level_e;
endpackage

// File: rtl/clamp_oneshot.sv
module clamp_oneshot #(
  parameter int unsigned CLAMP_W         = 7,
  parameter int unsigned CLAMP_DLY_LEAD  = 3,
  parameter int unsigned CLAMP_DLY_TRAIL = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic lead_sel_i,
  output logic lead_o,
  output logic clamp_o
);
  localparam int unsigned MAX_DLY = (CLAMP_DLY_LEAD > CLAMP_DLY_TRAIL) ?
                                    CLAMP_DLY_LEAD : CLAMP_DLY_TRAIL;
  localparam int unsigned CW = $clog2(MAX_DLY + CLAMP_W + 1);

  logic          hs_q, busy_q, trig;
  logic [CW-1:0] ctr_q, dly_q, last;

  assign lead_o = hsync_i & ~hs_q;
  assign trig   = lead_sel_i ? lead_o : (~hsync_i & hs_q);
  assign last   = dly_q + CW'(CLAMP_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q   <= 1'b0;
      busy_q <= 1'b0;
      ctr_q  <= '0;
      dly_q  <= '0;
    end else begin
      hs_q <= hsync_i;
      if (busy_q) begin
        if (ctr_q == last) busy_q <= 1'b0;
        else               ctr_q  <= ctr_q + CW'(1);
      end else if (trig) begin
        busy_q <= 1'b1;
        ctr_q  <= '0;
        dly_q  <= lead_sel_i ? CW'(CLAMP_DLY_LEAD) : CW'(CLAMP_DLY_TRAIL);
      end
    end
  end

  assign clamp_o = busy_q && (ctr_q >= dly_q);

  // sequence runs uninterrupted once started
  p_no_retrig_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ctr_q != last) |=> (busy_q && ctr_q == $past(ctr_q) + CW'(1)));
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && trig) |=> (busy_q && ctr_q == '0));
  p_clamp_in_seq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_o |-> (busy_q && ctr_q <= last));
endmodule

// File: rtl/vblank_timer.sv
module vblank_timer #(
  parameter int unsigned VBLANK_SHORT = 26,
  parameter int unsigned VBLANK_LONG  = 35
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vsync_i,
  input  logic scan_start_i,
  input  logic long_sel_i,
  output logic vblank_o
);
  localparam int unsigned MAXV = (VBLANK_LONG > VBLANK_SHORT) ? VBLANK_LONG : VBLANK_SHORT;
  localparam int unsigned VW   = $clog2(MAXV + 1);

  logic          vs_q, on_q, vs_rise;
  logic [VW-1:0] cnt_q, lim;

  assign vs_rise = vsync_i & ~vs_q;
  assign lim     = long_sel_i ? VW'(VBLANK_LONG - 1) : VW'(VBLANK_SHORT - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q  <= 1'b0;
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      vs_q <= vsync_i;
      if (vs_rise) begin
        on_q  <= 1'b1;
        cnt_q <= '0;
      end else if (on_q) begin
        if (scan_start_i || cnt_q == lim) on_q  <= 1'b0;
        else                              cnt_q <= cnt_q + VW'(1);
      end
    end
  end

  assign vblank_o = on_q;

  p_vb_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_rise |=> vblank_o);
  p_vb_scan_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vblank_o && scan_start_i && !vs_rise) |=> !vblank_o);
  p_vb_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_o |-> cnt_q <= VW'(MAXV - 1));
endmodule

// File: rtl/fault_blank.sv
module fault_blank #(
  parameter int unsigned MISS_LINES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lead_i,
  input  logic flyback_i,
  input  logic softstart_i,
  input  logic unlock_i,
  input  logic search_i,
  input  logic xray_i,
  input  logic low_supply_i,
  input  logic mask_unlock_i,
  output logic force_o
);
  localparam int unsigned MW = $clog2(MISS_LINES + 1);

  logic          fb_q, fb_rise, missing, unlock_cause;
  logic [MW-1:0] miss_q;

  assign fb_rise = flyback_i & ~fb_q;
  assign missing = (miss_q == MW'(MISS_LINES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_q   <= 1'b0;
      miss_q <= '0;
    end else begin
      fb_q <= flyback_i;
      if (fb_rise)                  miss_q <= '0;
      else if (lead_i && !missing)  miss_q <= miss_q + MW'(1);
    end
  end

  assign unlock_cause = unlock_i & search_i;
  assign force_o = softstart_i | xray_i | low_supply_i | missing |
                   (unlock_cause & ~mask_unlock_i);

  p_miss_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_q <= MW'(MISS_LINES));
  p_fb_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_rise |=> !missing);
  p_prot_force_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (softstart_i || xray_i || low_supply_i) |-> force_o);
endmodule

// File: rtl/sandcastle_gen.sv
module sandcastle_gen
  import sandcastle_pkg::*;
#(
  parameter int unsigned CLAMP_W         = 7,
  parameter int unsigned CLAMP_DLY_LEAD  = 3,
  parameter int unsigned CLAMP_DLY_TRAIL = 1,
  parameter int unsigned VBLANK_SHORT    = 26,
  parameter int unsigned VBLANK_LONG     = 35,
  parameter int unsigned MISS_LINES      = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hsync_i,
  input  logic       vsync_i,
  input  logic       vscan_start_i,
  input  logic       flyback_i,
  input  logic       softstart_i,
  input  logic       pll_unlock_i,
  input  logic       search_i,
  input  logic       xray_i,
  input  logic       low_supply_i,
  input  logic       clamp_lead_i,
  input  logic       vblank_long_i,
  input  logic       unlock_mask_i,
  output logic [1:0] level_o,
  output logic       unlock_blank_o
);
  logic      lead, clamp_act, vblank, force_blank, any_blank;
  sc_level_e level;

  clamp_oneshot #(
    .CLAMP_W(CLAMP_W), .CLAMP_DLY_LEAD(CLAMP_DLY_LEAD), .CLAMP_DLY_TRAIL(CLAMP_DLY_TRAIL)
  ) u_clamp (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .lead_sel_i(clamp_lead_i),
    .lead_o(lead), .clamp_o(clamp_act)
  );

  vblank_timer #(.VBLANK_SHORT(VBLANK_SHORT), .VBLANK_LONG(VBLANK_LONG)) u_vb (
    .clk_i(clk_i), .rst_ni(rst_ni), .vsync_i(vsync_i), .scan_start_i(vscan_start_i),
    .long_sel_i(vblank_long_i), .vblank_o(vblank)
  );

  fault_blank #(.MISS_LINES(MISS_LINES)) u_fault (
    .clk_i(clk_i), .rst_ni(rst_ni), .lead_i(lead), .flyback_i(flyback_i),
    .softstart_i(softstart_i), .unlock_i(pll_unlock_i), .search_i(search_i),
    .xray_i(xray_i), .low_supply_i(low_supply_i), .mask_unlock_i(unlock_mask_i),
    .force_o(force_blank)
  );

  assign any_blank = vblank | force_blank;

  always_comb begin
    if (clamp_act)      level = LVL_CLAMP;
    else if (any_blank) level = LVL_BLANK;
    else                level = LVL_NONE;
  end

  assign level_o        = level;
  assign unlock_blank_o = any_blank;

  p_clamp_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clamp_act && vblank) |-> level_o == 2'b10);
  p_ub_vb_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank |-> unlock_blank_o);
  p_mask_keeps_vb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlock_mask_i && !clamp_act && vblank) |-> level_o == 2'b01);
endmodule

// File: tb/tb_sandcastle_gen.sv
module tb_sandcastle_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 7;
  localparam int DL  = 3;
  localparam int DT  = 1;
  localparam int VBS = 26;
  localparam int VBL = 35;
  localparam int ML  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hs = 0, vs = 0, scan = 0, fb = 0, ss = 0, unl = 0, srch = 0, xr = 0, lowv = 0;
  logic lead_sel = 0, vlong = 0, umask = 0;
  logic [1:0] level;
  logic       ub;

  int checks = 0, failures = 0, wd = 0;
  string cur_req = "R1";

  sandcastle_gen #(.CLAMP_W(CW), .CLAMP_DLY_LEAD(DL), .CLAMP_DLY_TRAIL(DT),
                   .VBLANK_SHORT(VBS), .VBLANK_LONG(VBL), .MISS_LINES(ML)) dut (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .vsync_i(vs), .vscan_start_i(scan),
    .flyback_i(fb), .softstart_i(ss), .pll_unlock_i(unl), .search_i(srch), .xray_i(xr),
    .low_supply_i(lowv), .clamp_lead_i(lead_sel), .vblank_long_i(vlong),
    .unlock_mask_i(umask), .level_o(level), .unlock_blank_o(ub));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_age = -1, m_dly = 0, m_vb_cnt = 0, m_miss = 0;
  bit m_vb = 0, m_hs = 0, m_vs = 0, m_fb = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_age = -1; m_vb = 0; m_vb_cnt = 0; m_miss = 0; m_hs = 0; m_vs = 0; m_fb = 0;
    end else begin
      bit ld, tr, tg;
      int lim;
      ld = hs && !m_hs; tr = !hs && m_hs;
      tg = lead_sel ? ld : tr;
      if (m_age >= 0) begin
        if (m_age == m_dly + CW - 1) m_age = -1; else m_age++;
      end else if (tg) begin
        m_age = 0; m_dly = lead_sel ? DL : DT;
      end
      lim = vlong ? VBL : VBS;
      if (vs && !m_vs) begin m_vb = 1; m_vb_cnt = 0; end
      else if (m_vb) begin
        if (scan || m_vb_cnt == lim - 1) m_vb = 0; else m_vb_cnt++;
      end
      if (fb && !m_fb) m_miss = 0;
      else if (ld && m_miss < ML) m_miss++;
      m_hs = hs; m_vs = vs; m_fb = fb;
    end
  end

  function automatic bit exp_blank();
    return m_vb || ss || xr || lowv || (m_miss >= ML) || (unl && srch && !umask);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic [1:0] el;
      bit cl;
      cl = (m_age >= 0) && (m_age >= m_dly);
      el = cl ? 2'b10 : (exp_blank() ? 2'b01 : 2'b00);
      checks++;
      if (level !== el) begin
        failures++;
        $display("FAIL %s level_o actual=%b expected=%b t=%0t", cur_req, level, el, $time);
      end
      checks++;
      if (ub !== exp_blank()) begin
        failures++;
        $display("FAIL %s unlock_blank_o actual=%b expected=%b t=%0t", cur_req, ub, exp_blank(), $time);
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic line(int hi, int lo, bit with_fb);
    hs = 1; step(hi);
    hs = 0; if (with_fb) fb = 1; step(lo > 2 ? 2 : lo);
    fb = 0; if (lo > 2) step(lo - 2);
  endtask

  task automatic vpulse();
    vs = 1; step(3); vs = 0;
  endtask

  task automatic spot(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int cnt;

  initial begin
    step(3);
    #2 rst_n = 1; step(1);
    // R1 reset state
    spot("R1", int'(level), 0);
    spot("R1", int'(ub), 0);
    step(4);

    // R2 leading-edge clamp, directed width count
    cur_req = "R2"; lead_sel = 1;
    hs = 1; cnt = 0;
    for (int i = 0; i < 14; i++) begin @(negedge clk); if (level == 2'b10) cnt++; @(posedge clk); #1; if (i == 4) begin fb = 1; hs = 0; end else fb = 0; end
    spot("R2", cnt, CW);
    for (int i = 0; i < 6; i++) line(4, 16, 1);

    // R3 trailing-edge clamp
    cur_req = "R3"; lead_sel = 0;
    for (int i = 0; i < 6; i++) line(5, 15, 1);

    // R4 edges arrive faster than the sequence
    cur_req = "R4";
    for (int i = 0; i < 8; i++) begin hs = 1; step(2); hs = 0; fb = 1; step(1); fb = 0; step(1); end
    lead_sel = 1;
    for (int i = 0; i < 8; i++) begin hs = 1; step(2); hs = 0; fb = 1; step(1); fb = 0; step(1); end
    step(20);

    // R5 short blank length, no lines
    cur_req = "R5"; vlong = 0; cnt = 0;
    vs = 1;
    for (int i = 0; i < 60; i++) begin @(posedge clk); #1; if (i == 2) vs = 0; @(negedge clk); if (ub) cnt++; end
    spot("R5", cnt, VBS);
    vlong = 1; cnt = 0;
    vs = 1;
    for (int i = 0; i < 60; i++) begin @(posedge clk); #1; if (i == 2) vs = 0; @(negedge clk); if (ub) cnt++; end
    spot("R5", cnt, VBL);
    step(2);

    // R10 R11 blank with lines running: clamp overlaps blanking
    cur_req = "R10";
    fork
      begin for (int i = 0; i < 8; i++) line(4, 12, 1); end
      begin step(5); vpulse(); step(40); vlong = 0; vpulse(); end
    join
    cur_req = "R11";
    fork
      begin for (int i = 0; i < 6; i++) line(3, 9, 1); end
      begin step(2); vpulse(); step(10); vpulse(); end
    join
    step(40);

    // R6 scan start ends blank early
    cur_req = "R6";
    vpulse(); step(6); scan = 1; step(1); scan = 0; step(4);
    spot("R6", int'(ub), 0);
    step(30);

    // R7 protection faults
    cur_req = "R7";
    ss = 1; line(4, 12, 1); ss = 0; step(3);
    xr = 1; line(4, 12, 1); xr = 0; step(3);
    lowv = 1; step(2); spot("R7", int'(ub), 1); line(4, 12, 1); lowv = 0; step(3);

    // R8 unlock-caused blanking and its mask
    cur_req = "R8";
    unl = 1; step(4); srch = 1; line(4, 12, 1);
    umask = 1; step(3); spot("R8", int'(ub), 0);
    line(4, 12, 1);
    vpulse(); step(3); spot("R8", int'(level), 1);
    step(30);
    umask = 0; step(2); unl = 0; srch = 0; step(3);

    // R9 missing flyback
    cur_req = "R9";
    line(4, 12, 1);
    line(4, 12, 0);
    spot("R9", int'(ub), 0);
    line(4, 12, 0);
    spot("R9", int'(ub), 1);
    line(4, 12, 0);
    fb = 1; hs = 1; step(1); fb = 0; step(1);
    spot("R9", int'(ub), 0);
    hs = 0; step(10);
    line(4, 12, 1); line(4, 12, 1);
    step(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule